// File: doc/BRIEF.md
# Rollover Event Counter with Test Increment

A 16-bit statistics counter that tallies single-cycle event pulses, such as dropped incoming frames or collisions seen on the receive side. The count can be read at any time through the host read port. Whenever the controller is halted, the stop input clears the count to zero. When the count passes from all ones back to zero, a sticky overflow flag is raised. The flag stays up until the host clears it or the block is reset. A status register elsewhere in the chip maps this flag to one of its bits.

For production test, the host can step the counter without real traffic. While the test-enable input is high, each host write strobe adds one to the count. The write carries no data into the counter. While test-enable is low, host writes do nothing.

The overflow flag is held by a two-state machine. `FLAG_CLEAR` is the reset state. The transition *wrap-detected* moves `FLAG_CLEAR` to `FLAG_SET`. The transition *host-clear* moves `FLAG_SET` back to `FLAG_CLEAR`, except when a wrap happens in the same cycle. In every other case, each state holds.

Top module: `evt_rollover_counter`

## Requirements
- R1: Each cycle with `evt_pulse` high (and no other increment source and no stop) raises the count by exactly one on the next clock edge.
- R2: `cnt_rdata` always equals the current count, in every run state and at every test-enable setting.
- R3: A cycle with `stop_req` high leaves the count at zero after the next edge, whatever increments are requested in that cycle. Such a cycle never raises the flag.
- R4: With `test_en` high, a cycle with `host_wr` high adds one to the count.
- R5: With `test_en` low, `host_wr` has no effect on the count or the flag.
- R6: An increment that takes the count from 65535 (16'hFFFF) to 0 sets `ovf_flag` on the next edge.
- R7: `ovf_flag` stays high until a cycle with `ovf_clr` high and no wrap. It then reads low after the next edge. A wrap in the same cycle as `ovf_clr` keeps the flag high.
- R8: An event and a test write in the same cycle add two to the count. A wrap caused by either source sets the flag (for example, 16'hFFFE plus two gives 0 with the flag set).
- R9: After reset the count is 0 and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 1 | Single-cycle event to be counted |
| stop_req | input | 1 | Controller halted; clears the count |
| test_en | input | 1 | Lets host writes act as increments |
| host_wr | input | 1 | Host write strobe to the counter address |
| cnt_rdata | output | 16 | Current count, always readable |
| ovf_flag | output | 1 | Sticky rollover flag |
| ovf_clr | input | 1 | Host clear of the rollover flag |

## Verification
On every cycle, the embedded assertions check the following: a single step per lone event, the clear after stop, a test-disabled write leaving the count alone, a flag set after a wrap from all ones, and the flag's stickiness. Only the bench scenarios show the rest. These are the double step when both sources coincide, the wrap reached from 16'hFFFE by two, a wrap overriding a simultaneous host clear, and the full 65536-event lap that actually reaches the rollover.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/evc_step.sv
module evc_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             inc_a,
    input  logic             inc_b,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap
);
    localparam int SW = WIDTH + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum  = {1'b0, cur} + SW'(inc_a) + SW'(inc_b);
        nxt  = sum[WIDTH-1:0];
        wrap = sum[WIDTH];
    end
endmodule

// File: rtl/evc_flag_fsm.sv
module evc_flag_fsm
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_hit,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (wrap_hit) state_d = FLAG_SET;
            FLAG_SET:   if (clr_req && !wrap_hit) state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end

    // R7: flag holds unless cleared without a wrap
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !wrap_hit) |=> !flag);
endmodule

// File: rtl/evt_rollover_counter.sv
module evt_rollover_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pulse,
    input  logic             stop_req,
    input  logic             test_en,
    input  logic             host_wr,
    output logic [WIDTH-1:0] cnt_rdata,
    output logic             ovf_flag,
    input  logic             ovf_clr
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] count_q, count_nxt;
    logic             test_inc, raw_wrap, wrap_eff;

    assign test_inc = test_en & host_wr;

    evc_step #(.WIDTH(WIDTH)) u_step (
        .cur   (count_q),
        .inc_a (evt_pulse),
        .inc_b (test_inc),
        .nxt   (count_nxt),
        .wrap  (raw_wrap)
    );

    assign wrap_eff = raw_wrap & ~stop_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count_q <= '0;
        else if (stop_req) count_q <= '0;
        else               count_q <= count_nxt;
    end

    evc_flag_fsm u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_hit (wrap_eff),
        .clr_req  (ovf_clr),
        .flag     (ovf_flag)
    );

    assign cnt_rdata = count_q;

    p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && !test_inc && !stop_req) |=> count_q == WIDTH'($past(count_q) + 1'b1));
    p_stop_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> count_q == '0);
    p_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !test_en && !evt_pulse && !stop_req) |=> $stable(count_q));
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == ALL_ONES && evt_pulse && !stop_req) |=> ovf_flag);
endmodule

// File: tb/evt_rollover_counter_tb.sv
`timescale 1ns/1ps
module evt_rollover_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pulse = 1'b0, stop_req = 1'b0, test_en = 1'b0, host_wr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] cnt_rdata;
    logic        ovf_flag;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    evt_rollover_counter u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .stop_req(stop_req),
        .test_en(test_en), .host_wr(host_wr), .cnt_rdata(cnt_rdata),
        .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    // vector: [20]evt [19]stop [18]ten [17]wr [16:1]expected count [0]expected flag
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 16'd1, 1'b0},   // R1
        {1'b1, 1'b0, 1'b0, 1'b0, 16'd2, 1'b0},   // R1
        {1'b0, 1'b0, 1'b0, 1'b1, 16'd2, 1'b0},   // R5
        {1'b0, 1'b0, 1'b1, 1'b1, 16'd3, 1'b0},   // R4
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd5, 1'b0},   // R8
        {1'b1, 1'b1, 1'b1, 1'b1, 16'd0, 1'b0},   // R3
        {1'b1, 1'b0, 1'b1, 1'b0, 16'd1, 1'b0},   // R2
        {1'b0, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0}    // R3
    };

    function automatic string vtag(int i);
        case (i)
            0, 1: return "R1";
            2: return "R5";
            3: return "R4";
            4: return "R8";
            5, 7: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] ecnt, logic eflag);
        total++;
        if (cnt_rdata !== ecnt || ovf_flag !== eflag) begin
            bad++;
            $display("FAIL %s: cnt=%h flag=%b expected cnt=%h flag=%b",
                     tag, cnt_rdata, ovf_flag, ecnt, eflag);
        end
    endtask

    task automatic idle_inputs();
        evt_pulse = 0; stop_req = 0; test_en = 0; host_wr = 0; ovf_clr = 0;
    endtask

    task automatic run_events(int n);
        @(negedge clk);
        evt_pulse = 1;
        repeat (n) @(negedge clk);
        evt_pulse = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: expired before completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", 16'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 16'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {evt_pulse, stop_req, test_en, host_wr} = VEC[i][20:17];
            @(negedge clk);
            idle_inputs();
            check(vtag(i), VEC[i][16:1], VEC[i][0]);
        end

        // R8: lap to FFFE, then both sources wrap to zero
        run_events(65534);
        check("R1", 16'hFFFE, 1'b0);
        evt_pulse = 1; test_en = 1; host_wr = 1;
        @(negedge clk); idle_inputs();
        check("R8", 16'h0000, 1'b1);
        repeat (3) @(negedge clk);
        check("R7", 16'h0000, 1'b1);
        // R5: disabled write leaves flag and count
        host_wr = 1;
        @(negedge clk); idle_inputs();
        check("R5", 16'h0000, 1'b1);
        ovf_clr = 1;
        @(negedge clk); idle_inputs();
        check("R7", 16'h0000, 1'b0);

        // R6: second lap, wrap with a simultaneous clear keeps the flag
        run_events(65535);
        check("R2", 16'hFFFF, 1'b0);
        evt_pulse = 1; ovf_clr = 1;
        @(negedge clk); idle_inputs();
        check("R6", 16'h0000, 1'b1);

        // R3: stop clears count, flag unchanged
        run_events(4);
        stop_req = 1; evt_pulse = 1;
        @(negedge clk); idle_inputs();
        check("R3", 16'h0000, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule